// File: doc/BRIEF.md
# Reorder Buffer Retire and Squash Controller

This controller sits at the retire end of an out-of-order pipeline, beside a reorder buffer whose storage lives elsewhere. It watches a window of entries at the buffer head, retires the completed ones in program order, and holds back non-speculative instructions until they reach the head. When one does, the controller tells the issue logic which instruction may now run.

Execute units may send redirect requests tagged with the sequence number of the instruction that caused them. The controller keeps the sequence number of the youngest instruction that is still valid in the buffer. Only a redirect from an instruction older than that register becomes a squash broadcast. After a broadcast, the buffer removes the wrong-path entries over several cycles. During that time the controller asks for the drain, counts what is removed, and retires nothing.

The controller also keeps its own count of buffer occupancy. It reports the number of free entries and raises a strobe in every cycle where that number changed.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After reset the state output reads idle (0), the free count equals DEPTH, and every strobe output is low.
- R2: Each cycle outside squashing, `ret_mask` marks the longest run of head lanes, starting at lane 0, whose entries are valid and done. At most CMT_W lanes are marked, and the mask appears on the cycle after the head view is presented.
- R3: When lane 0 holds a valid, not-done, non-speculative entry, `ns_go` pulses once for that sequence number and `ns_seq` carries it. A second pulse is never given for the same head entry.
- R4: Among the valid redirect lanes, only the one with the smallest sequence number is considered. When several lanes share that number, the lowest lane wins.
- R5: The considered redirect is broadcast only if its sequence number is strictly less than the tracked youngest sequence number. Otherwise it is ignored and leaves no trace on any output.
- R6: An accepted redirect sets the youngest register to its own sequence number. A later redirect whose number is equal or greater is then ignored, including one that arrives during squashing.
- R7: A broadcast pulses `sq_go` for one cycle on the cycle after acceptance, with the boundary sequence number, the target PC and the mispredict flag of the accepted redirect.
- R8: From the broadcast until `drain_done` is seen, the state reads squashing (2) and `drain_req` is high. No entry retires, no non-speculative release is made, and allocations are ignored.
- R9: Occupancy falls by `drain_cnt` on each squashing cycle. After `drain_done`, the state reads idle (0) if occupancy is zero and running (1) otherwise.
- R10: Allocation lanes taken outside squashing raise occupancy, and the youngest register takes the highest valid lane's sequence number.
- R11: `free_cnt` equals DEPTH minus occupancy. `free_upd` pulses on the cycle after any allocation, retirement or drain changed occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_valid | input | CMT_W | Head window lane holds an entry (lane 0 is the head) |
| hd_done | input | CMT_W | Head window entry has completed |
| hd_nspec | input | CMT_W | Head window entry is non-speculative |
| hd_seq | input | CMT_W*SEQ_W | Head window sequence numbers, lane i in slice i |
| al_valid | input | AL_W | Allocation lanes, higher lane is younger |
| al_seq | input | AL_W*SEQ_W | Allocated sequence numbers |
| rd_valid | input | RD_N | Redirect request per execute port |
| rd_seq | input | RD_N*SEQ_W | Sequence number of the redirecting instruction |
| rd_pc | input | RD_N*PC_W | Redirect target PC |
| rd_misp | input | RD_N | Redirect is a branch mispredict |
| drain_cnt | input | SQ_CW | Entries the buffer removed this cycle |
| drain_done | input | 1 | Buffer reports squash removal complete |
| ret_mask | output | CMT_W | Head lanes retired |
| ns_go | output | 1 | Non-speculative head instruction may issue |
| ns_seq | output | SEQ_W | Sequence number released |
| sq_go | output | 1 | Squash broadcast strobe |
| sq_seq | output | SEQ_W | Squash boundary; younger entries are removed |
| sq_pc | output | PC_W | Restart PC |
| sq_misp | output | 1 | Squash caused by a branch mispredict |
| drain_req | output | 1 | Asks the buffer to remove up to SQ_W entries |
| state | output | 2 | 0 idle, 1 running, 2 squashing |
| free_cnt | output | CNT_W | Free buffer entries |
| free_upd | output | 1 | Free count changed |

## Verification
The bench targets the edges of the age filter. A redirect equal to the youngest number must be dropped, and of two same-cycle redirects the older one must win. A stale redirect arriving mid-squash must also be dropped; a design using less-or-equal, picking by lane, or not overwriting the youngest register would broadcast spuriously or carry the wrong PC. Retirement is checked when an incomplete entry sits in the middle of the window: a design that skips over it retires out of order. Retirement is also checked for the width cap. The non-speculative head is held for two cycles, which exposes a release that repeats every cycle. During a multi-cycle drain the bench keeps done entries and allocations arriving, so a design that retires or counts them while squashing shows a wrong mask or free count.

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl #(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CMT_W = 4,
  parameter int SQ_W  = 2,
  parameter int AL_W  = 2,
  parameter int RD_N  = 2,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SQ_CW = $clog2(SQ_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CMT_W-1:0]        hd_valid,
  input  logic [CMT_W-1:0]        hd_done,
  input  logic [CMT_W-1:0]        hd_nspec,
  input  logic [CMT_W*SEQ_W-1:0]  hd_seq,
  input  logic [AL_W-1:0]         al_valid,
  input  logic [AL_W*SEQ_W-1:0]   al_seq,
  input  logic [RD_N-1:0]         rd_valid,
  input  logic [RD_N*SEQ_W-1:0]   rd_seq,
  input  logic [RD_N*PC_W-1:0]    rd_pc,
  input  logic [RD_N-1:0]         rd_misp,
  input  logic [SQ_CW-1:0]        drain_cnt,
  input  logic                    drain_done,
  output logic [CMT_W-1:0]        ret_mask,
  output logic                    ns_go,
  output logic [SEQ_W-1:0]        ns_seq,
  output logic                    sq_go,
  output logic [SEQ_W-1:0]        sq_seq,
  output logic [PC_W-1:0]         sq_pc,
  output logic                    sq_misp,
  output logic                    drain_req,
  output logic [1:0]              state,
  output logic [CNT_W-1:0]        free_cnt,
  output logic                    free_upd
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_SQ = 2'd2;

  logic [1:0]       st_q;
  logic [SEQ_W-1:0] yng_q;
  logic [CNT_W-1:0] occ_q;
  logic             nsd_v_q;
  logic [SEQ_W-1:0] nsd_seq_q;

  wire squashing = (st_q == ST_SQ);

  // oldest redirect pick
  logic             pk_v;
  logic [SEQ_W-1:0] pk_seq;
  logic [PC_W-1:0]  pk_pc;
  logic             pk_misp;
  always_comb begin
    pk_v = 1'b0; pk_seq = '0; pk_pc = '0; pk_misp = 1'b0;
    for (int i = 0; i < RD_N; i++) begin
      if (rd_valid[i] && (!pk_v || rd_seq[i*SEQ_W +: SEQ_W] < pk_seq)) begin
        pk_v    = 1'b1;
        pk_seq  = rd_seq[i*SEQ_W +: SEQ_W];
        pk_pc   = rd_pc[i*PC_W +: PC_W];
        pk_misp = rd_misp[i];
      end
    end
  end
  wire accept = pk_v && (pk_seq < yng_q);
  wire quiet  = !squashing && !accept;

  // in-order retire run from the head
  logic [CMT_W-1:0] ret_c;
  logic [CNT_W-1:0] ret_n;
  always_comb begin
    logic run;
    run = quiet;
    ret_c = '0; ret_n = '0;
    for (int i = 0; i < CMT_W; i++) begin
      run = run && hd_valid[i] && hd_done[i];
      ret_c[i] = run;
      if (run) ret_n = ret_n + 1'b1;
    end
  end

  // allocation count and youngest lane
  logic [CNT_W-1:0] al_n;
  logic [SEQ_W-1:0] al_last;
  always_comb begin
    al_n = '0; al_last = yng_q;
    for (int i = 0; i < AL_W; i++) begin
      if (al_valid[i]) begin
        al_n    = al_n + 1'b1;
        al_last = al_seq[i*SEQ_W +: SEQ_W];
      end
    end
  end
  wire [CNT_W-1:0] al_take = quiet ? al_n : '0;
  wire [CNT_W-1:0] dr_take = squashing ? CNT_W'(drain_cnt) : '0;
  wire [CNT_W-1:0] occ_d   = occ_q + al_take - ret_n - dr_take;

  wire ns_fire = quiet && hd_valid[0] && hd_nspec[0] && !hd_done[0] &&
                 !(nsd_v_q && nsd_seq_q == hd_seq[SEQ_W-1:0]);

  logic [1:0] st_d;
  always_comb begin
    if (accept)                         st_d = ST_SQ;
    else if (squashing && !drain_done)  st_d = ST_SQ;
    else                                st_d = (occ_d == '0) ? ST_IDLE : ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      yng_q     <= '0;
      occ_q     <= '0;
      nsd_v_q   <= 1'b0;
      nsd_seq_q <= '0;
      ret_mask  <= '0;
      ns_go     <= 1'b0;
      ns_seq    <= '0;
      sq_go     <= 1'b0;
      sq_seq    <= '0;
      sq_pc     <= '0;
      sq_misp   <= 1'b0;
      free_upd  <= 1'b0;
    end else begin
      st_q     <= st_d;
      occ_q    <= occ_d;
      ret_mask <= ret_c;
      ns_go    <= ns_fire;
      sq_go    <= accept;
      free_upd <= (al_take != '0) || (ret_n != '0) || (dr_take != '0);
      if (accept)                 yng_q <= pk_seq;
      else if (quiet && al_n != 0) yng_q <= al_last;
      if (ns_fire) begin
        nsd_v_q   <= 1'b1;
        nsd_seq_q <= hd_seq[SEQ_W-1:0];
        ns_seq    <= hd_seq[SEQ_W-1:0];
      end else if (ret_n != '0) begin
        nsd_v_q <= 1'b0;
      end
      if (accept) begin
        sq_seq  <= pk_seq;
        sq_pc   <= pk_pc;
        sq_misp <= pk_misp;
      end
    end
  end

  assign drain_req = squashing;
  assign state     = st_q;
  assign free_cnt  = CNT_W'(DEPTH) - occ_q;
endmodule

module rob_retire_ctrl_chk #(
  parameter int SEQ_W = 16,
  parameter int CMT_W = 4,
  parameter int SQ_W  = 2,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int SQ_CW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       state,
  input logic [CMT_W-1:0] ret_mask,
  input logic             ns_go,
  input logic [SEQ_W-1:0] ns_seq,
  input logic             sq_go,
  input logic [SEQ_W-1:0] sq_seq,
  input logic [SEQ_W-1:0] yng_q,
  input logic [CNT_W-1:0] occ_q,
  input logic             drain_req,
  input logic [SQ_CW-1:0] drain_cnt
);
  a_r2_no_ret_in_squash: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2) |=> (ret_mask == '0));
  a_r2_ret_prefix: assert property (@(posedge clk) disable iff (rst)
    ((ret_mask & (ret_mask + 1'b1)) == '0));
  a_r3_single_release: assert property (@(posedge clk) disable iff (rst)
    ns_go |=> (!ns_go || ns_seq != $past(ns_seq)));
  a_r5_only_older: assert property (@(posedge clk) disable iff (rst)
    sq_go |-> (sq_seq < $past(yng_q)));
  a_r6_youngest_moves: assert property (@(posedge clk) disable iff (rst)
    sq_go |-> (yng_q == sq_seq));
  a_r8_squash_state: assert property (@(posedge clk) disable iff (rst)
    sq_go |-> (state == 2'd2 && drain_req));
  a_r8_no_release_in_squash: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2) |=> !ns_go);
  a_r9_drain_rate: assert property (@(posedge clk) disable iff (rst)
    drain_req |-> (drain_cnt <= SQ_CW'(SQ_W)));
  a_r11_occ_bound: assert property (@(posedge clk) disable iff (rst)
    (occ_q <= CNT_W'(DEPTH)));
endmodule

bind rob_retire_ctrl rob_retire_ctrl_chk #(
  .SEQ_W(SEQ_W), .CMT_W(CMT_W), .SQ_W(SQ_W), .DEPTH(DEPTH),
  .CNT_W(CNT_W), .SQ_CW(SQ_CW)
) i_chk (
  .clk(clk), .rst(rst), .state(state), .ret_mask(ret_mask),
  .ns_go(ns_go), .ns_seq(ns_seq), .sq_go(sq_go), .sq_seq(sq_seq),
  .yng_q(yng_q), .occ_q(occ_q), .drain_req(drain_req), .drain_cnt(drain_cnt)
);

// File: tb/test_rob_retire_ctrl.sv
module test_rob_retire_ctrl;
  localparam int SEQ_W = 16, PC_W = 32, CMT_W = 4, SQ_W = 2, AL_W = 2, RD_N = 2, DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1), SQ_CW = $clog2(SQ_W + 1);

  logic clk = 0, rst = 1;
  logic [CMT_W-1:0] hd_valid, hd_done, hd_nspec;
  logic [CMT_W*SEQ_W-1:0] hd_seq;
  logic [AL_W-1:0] al_valid;
  logic [AL_W*SEQ_W-1:0] al_seq;
  logic [RD_N-1:0] rd_valid, rd_misp;
  logic [RD_N*SEQ_W-1:0] rd_seq;
  logic [RD_N*PC_W-1:0] rd_pc;
  logic [SQ_CW-1:0] drain_cnt;
  logic drain_done;
  logic [CMT_W-1:0] ret_mask;
  logic ns_go, sq_go, sq_misp, drain_req, free_upd;
  logic [SEQ_W-1:0] ns_seq, sq_seq;
  logic [PC_W-1:0] sq_pc;
  logic [1:0] state;
  logic [CNT_W-1:0] free_cnt;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rob_retire_ctrl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CMT_W(CMT_W), .SQ_W(SQ_W),
    .AL_W(AL_W), .RD_N(RD_N), .DEPTH(DEPTH)) i_rob_retire_ctrl (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    hd_valid = '0; hd_done = '0; hd_nspec = '0; hd_seq = '0;
    al_valid = '0; al_seq = '0; rd_valid = '0; rd_misp = '0;
    rd_seq = '0; rd_pc = '0; drain_cnt = '0; drain_done = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic alloc2(int s);
    al_valid = 2'b11; al_seq = {16'(s + 1), 16'(s)};
    step(); idle_in();
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 free", free_cnt, DEPTH);
    chk("R1 strobes", {ret_mask, ns_go, sq_go, free_upd, drain_req}, 0);
  endtask

  task automatic t_alloc();
    alloc2(10);
    chk("R10 free after alloc", free_cnt, 14);
    chk("R11 free_upd", free_upd, 1);
    chk("R10 state run", state, 1);
    alloc2(12);
    chk("R11 free 12", free_cnt, 12);
  endtask

  task automatic t_retire_gap();
    hd_valid = 4'b1111; hd_done = 4'b1011; hd_seq = {16'd13, 16'd12, 16'd11, 16'd10};
    step(); idle_in();
    chk("R2 stop at gap", ret_mask, 4'b0011);
    chk("R11 free after retire", free_cnt, 14);
    hd_valid = 4'b0011; hd_done = 4'b0011; hd_seq = {32'd0, 16'd13, 16'd12};
    step(); idle_in();
    chk("R2 tail retire", ret_mask, 4'b0011);
    chk("R9 idle when empty", state, 0);
    step();
    chk("R11 no change no upd", free_upd, 0);
  endtask

  task automatic t_nonspec();
    al_valid = 2'b01; al_seq = 32'd20; step(); idle_in();
    hd_valid = 4'b0001; hd_nspec = 4'b0001; hd_seq = 64'd20;
    step();
    chk("R3 release", ns_go, 1);
    chk("R3 release seq", ns_seq, 20);
    chk("R2 held nonspec", ret_mask, 0);
    step();
    chk("R3 no repeat", ns_go, 0);
    hd_done = 4'b0001; step(); idle_in();
    chk("R2 nonspec retires", ret_mask, 4'b0001);
    chk("R3 no release when done", ns_go, 0);
  endtask

  task automatic t_width();
    for (int k = 0; k < 4; k++) alloc2(30 + 2 * k);
    hd_valid = 4'b1111; hd_done = 4'b1111; hd_seq = {16'd33, 16'd32, 16'd31, 16'd30};
    step(); idle_in();
    chk("R2 width cap", ret_mask, 4'b1111);
    chk("R11 free 12", free_cnt, 12);
  endtask

  task automatic t_redirect();
    rd_valid = 2'b01; rd_seq = 32'd40; step(); idle_in();
    chk("R5 younger ignored", sq_go, 0);
    rd_valid = 2'b01; rd_seq = 32'd37; step(); idle_in();
    chk("R5 equal ignored", sq_go, 0);
    chk("R5 state unchanged", state, 1);
    rd_valid = 2'b11; rd_seq = {16'd33, 16'd36};
    rd_pc = {32'hB000, 32'hA000}; rd_misp = 2'b10;
    step(); idle_in();
    chk("R7 broadcast", sq_go, 1);
    chk("R4 oldest seq", sq_seq, 33);
    chk("R4 oldest pc", sq_pc, 32'hB000);
    chk("R7 mispredict", sq_misp, 1);
    chk("R8 squashing", state, 2);
    rd_valid = 2'b01; rd_seq = 32'd35; rd_pc = 32'hC000;
    hd_valid = 4'b0001; hd_done = 4'b0001; hd_seq = 64'd34;
    al_valid = 2'b01; al_seq = 32'd50;
    drain_cnt = 2;
    step(); idle_in();
    chk("R6 stale ignored", sq_go, 0);
    chk("R8 no retire", ret_mask, 0);
    chk("R8 drain req", drain_req, 1);
    chk("R9 free after drain", free_cnt, 14);
    drain_cnt = 2; drain_done = 1;
    step(); idle_in();
    chk("R9 idle after drain", state, 0);
    chk("R9 free full", free_cnt, 16);
    chk("R8 drain released", drain_req, 0);
  endtask

  task automatic t_tie();
    alloc2(60);
    rd_valid = 2'b11; rd_seq = {16'd60, 16'd60}; rd_pc = {32'h2, 32'h1}; rd_misp = 2'b01;
    step(); idle_in();
    chk("R4 tie lowest lane pc", sq_pc, 1);
    chk("R7 tie misp", sq_misp, 1);
    drain_cnt = 1; drain_done = 1; step(); idle_in();
    chk("R9 run after drain", state, 1);
    chk("R11 free 15", free_cnt, 15);
  endtask

  initial begin
    fork
      begin
        idle_in();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #2;
        t_reset();
        t_alloc();
        t_retire_gap();
        t_nonspec();
        t_width();
        t_redirect();
        t_tie();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule